// File: doc/BRIEF.md
# Private Interrupt State Holder for One Processor

This block keeps the interrupt state of one processor's 32 private interrupt sources: sixteen software-generated sources (IDs 0 to 15) and sixteen private peripheral sources (IDs 16 to 31). For every source it holds an enable bit, a pending bit, an active bit and a group bit. It also stores an 8-bit priority per source and two 32-bit configuration words. From this state it derives two request lines for the processor. IRQ serves group-1 sources and FIQ serves group-0 sources.

Software reaches the state through a 32-bit, word-addressed register port. The port has a single-cycle write strobe and a combinational read data path. The enable, pending and active bitmaps each have two addresses. One address sets the bits written as 1, the other clears them, and both read back the same bitmap. Two dedicated input vectors let hardware sources raise or drop their own pending bits. A source counts as forwardable while it is pending, enabled and not active. Each request line is asserted when some forwardable source belongs to its group and that group's enable input is high.

Top module: `pirq_state`

## Requirements
- R1: A source is forwardable only while its pending bit is 1, its enable bit is 1 and its active bit is 0. Setting the active bit of the only forwardable source drops its request line, and clearing it raises the line again.
- R2: `irq` is 1 exactly when some forwardable source has group bit 1 and `grp1_en` is 1.
- R3: `fiq` is 1 exactly when some forwardable source has group bit 0 and `grp0_en` is 1.
- R4: When no source is forwardable, both `irq` and `fiq` are 0.
- R5: The word addresses are as follows: enable-set 1, enable-clear 2, pending-set 3, pending-clear 4, active-set 5, active-clear 6. A write to a set address ORs `wdata` into the bitmap. A write to a clear address removes the bits that are 1 in `wdata`.
- R6: For each bitmap, the set address and the clear address both read back the current bitmap, with bit n holding source n.
- R7: Priority words sit at addresses 16 to 23. Word i holds the priorities of sources 4i to 4i+3, with source 4i in bits 7:0 and source 4i+3 in bits 31:24. A word reads back as written and does not disturb the other words.
- R8: Configuration words at addresses 8 and 9 are plain 32-bit read/write storage. Every address not named in R5, R7, R8 or R10 reads as 0.
- R9: A rising edge on `sgi_in[k]` sets pending bit k, and a falling edge clears it. The same holds for `ppi_in[k]` and pending bit 16+k. A level held high does not set the bit again after a register write has cleared it.
- R10: A write to address 0 replaces the whole group bitmap with `wdata`.
- R11: Reset clears every bitmap, priority word and configuration word, and drives `irq` and `fiq` to 0. Both request lines are registered and follow a state change one clock later.
- R12: When a hardware edge and a pending-register write hit the same pending bit in the same cycle, the register write decides the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | 5 | Word address for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| sgi_in | input | 16 | Software-generated source levels, bit k drives pending bit k |
| ppi_in | input | 16 | Private peripheral source levels, bit k drives pending bit 16+k |
| grp0_en | input | 1 | Group-0 enable, gates `fiq` |
| grp1_en | input | 1 | Group-1 enable, gates `irq` |
| irq | output | 1 | Group-1 interrupt request |
| fiq | output | 1 | Group-0 interrupt request |

## Verification
A register write or an input edge changes the state at the clock edge where it is sampled, so `rdata` shows the new value right after that edge. `irq` and `fiq` follow one edge later. The bench drives stimulus on the falling edge and reads `rdata` half a cycle after the edge that made the change. For the request lines it first confirms they have not yet moved at that point, and it checks them again one full cycle later. Changes to the group enables alone reach the lines at the next rising edge, and the bench checks them at the falling edge that follows.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   localparam int unsigned ADDR_W = 5;

   typedef enum logic [ADDR_W-1:0] {
      A_GROUP  = 5'd0,
      A_EN_SET = 5'd1,
      A_EN_CLR = 5'd2,
      A_PD_SET = 5'd3,
      A_PD_CLR = 5'd4,
      A_AC_SET = 5'd5,
      A_AC_CLR = 5'd6
   } reg_addr_e;

   localparam logic [ADDR_W-1:0] CFG_BASE  = 5'd8;
   localparam logic [ADDR_W-1:0] PRIO_BASE = 5'd16;
endpackage

// File: rtl/pirq_edge.sv
// Per-bit edge detector for hardware interrupt source levels.
module pirq_edge #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lvl[b];
      end
      assign rise[b] = lvl[b] & ~prev_q;
      assign fall[b] = ~lvl[b] & prev_q;
   end
endmodule

// File: rtl/pirq_bitmap.sv
// Bitmap with hardware set/clear events, then software set/clear on top
// (software applied last so it wins on a shared bit).
module pirq_bitmap #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] hw_set,
   input  logic [W-1:0] hw_clr,
   input  logic [W-1:0] sw_set,
   input  logic [W-1:0] sw_clr,
   output logic [W-1:0] q
);
   logic [W-1:0] after_hw;
   assign after_hw = (q | hw_set) & ~hw_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (after_hw | sw_set) & ~sw_clr;
   end
endmodule

// File: rtl/pirq_prio_bank.sv
// Byte-packed priority storage: word i holds sources 4i..4i+3, lowest in low byte.
module pirq_prio_bank #(
   parameter int unsigned NUM_INT = 32,
   parameter int unsigned PRIO_W  = 8,
   parameter int unsigned DATA_W  = 32,
   localparam int unsigned WORDS  = NUM_INT * PRIO_W / DATA_W,
   localparam int unsigned IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] word_q [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         word_q[w] <= '0;
         else if (wr && idx == IDX_W'(w))    word_q[w] <= wdata;
      end
   end

   assign rdata = word_q[idx];
endmodule

// File: rtl/pirq_fwd.sv
// Registered IRQ/FIQ derivation from forwardable sources.
module pirq_fwd #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pend,
   input  logic [W-1:0] en,
   input  logic [W-1:0] act,
   input  logic [W-1:0] grp,
   input  logic         g0_en,
   input  logic         g1_en,
   output logic         irq,
   output logic         fiq
);
   logic [W-1:0] fwd;
   assign fwd = pend & en & ~act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq <= 1'b0;
         fiq <= 1'b0;
      end else begin
         irq <= (|(fwd & grp))  & g1_en;
         fiq <= (|(fwd & ~grp)) & g0_en;
      end
   end
endmodule

// File: rtl/pirq_state.sv
module pirq_state
   import pirq_pkg::*;
#(
   parameter int unsigned NUM_SGI = 16,
   parameter int unsigned NUM_PPI = 16,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned PRIO_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [pirq_pkg::ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]         wdata,
   output logic [DATA_W-1:0]         rdata,
   input  logic [NUM_SGI-1:0]        sgi_in,
   input  logic [NUM_PPI-1:0]        ppi_in,
   input  logic                      grp0_en,
   input  logic                      grp1_en,
   output logic                      irq,
   output logic                      fiq
);
   localparam int unsigned NUM_INT    = NUM_SGI + NUM_PPI;
   localparam int unsigned PRIO_WORDS = NUM_INT * PRIO_W / DATA_W;
   localparam int unsigned PIDX_W     = (PRIO_WORDS > 1) ? $clog2(PRIO_WORDS) : 1;
   localparam int unsigned CFG_WORDS  = 2 * NUM_INT / DATA_W;
   localparam int unsigned CIDX_W     = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1;
   localparam logic [ADDR_W-1:0] PRIO_END = ADDR_W'(PRIO_BASE + PRIO_WORDS);
   localparam logic [ADDR_W-1:0] CFG_END  = ADDR_W'(CFG_BASE + CFG_WORDS);

   if (NUM_INT != DATA_W) begin : g_bad_count
      $error("source count must equal the data width");
   end
   if ((DATA_W % PRIO_W) != 0) begin : g_bad_prio
      $error("priority width must divide the data width");
   end
   if (CFG_END > PRIO_BASE || int'(PRIO_BASE) + PRIO_WORDS > (1 << ADDR_W)) begin : g_bad_map
      $error("register windows overlap or exceed the address space");
   end

   // ---------------- write decode ----------------
   logic wr_grp, wr_ens, wr_enc, wr_pds, wr_pdc, wr_acs, wr_acc;
   logic prio_hit, cfg_hit;
   logic [PIDX_W-1:0] prio_idx;
   logic [CIDX_W-1:0] cfg_idx;

   assign wr_grp   = wr_en && addr == A_GROUP;
   assign wr_ens   = wr_en && addr == A_EN_SET;
   assign wr_enc   = wr_en && addr == A_EN_CLR;
   assign wr_pds   = wr_en && addr == A_PD_SET;
   assign wr_pdc   = wr_en && addr == A_PD_CLR;
   assign wr_acs   = wr_en && addr == A_AC_SET;
   assign wr_acc   = wr_en && addr == A_AC_CLR;
   assign prio_hit = (addr >= PRIO_BASE) && (addr < PRIO_END);
   assign cfg_hit  = (addr >= CFG_BASE)  && (addr < CFG_END);
   assign prio_idx = PIDX_W'(addr - PRIO_BASE);
   assign cfg_idx  = CIDX_W'(addr - CFG_BASE);

   // ---------------- state ----------------
   logic [NUM_INT-1:0] en_q, pend_q, act_q, grp_q;
   logic [NUM_SGI-1:0] sgi_rise, sgi_fall;
   logic [NUM_PPI-1:0] ppi_rise, ppi_fall;
   logic [DATA_W-1:0]  prio_rdata;
   logic [DATA_W-1:0]  cfg_q [CFG_WORDS];

   pirq_edge #(.W(NUM_SGI)) u_sgi_edge (
      .clk(clk), .rst_n(rst_n), .lvl(sgi_in), .rise(sgi_rise), .fall(sgi_fall));
   pirq_edge #(.W(NUM_PPI)) u_ppi_edge (
      .clk(clk), .rst_n(rst_n), .lvl(ppi_in), .rise(ppi_rise), .fall(ppi_fall));

   pirq_bitmap #(.W(NUM_INT)) u_en (
      .clk(clk), .rst_n(rst_n), .hw_set('0), .hw_clr('0),
      .sw_set(wr_ens ? wdata : '0), .sw_clr(wr_enc ? wdata : '0), .q(en_q));

   pirq_bitmap #(.W(NUM_INT)) u_pend (
      .clk(clk), .rst_n(rst_n),
      .hw_set({ppi_rise, sgi_rise}), .hw_clr({ppi_fall, sgi_fall}),
      .sw_set(wr_pds ? wdata : '0), .sw_clr(wr_pdc ? wdata : '0), .q(pend_q));

   pirq_bitmap #(.W(NUM_INT)) u_act (
      .clk(clk), .rst_n(rst_n), .hw_set('0), .hw_clr('0),
      .sw_set(wr_acs ? wdata : '0), .sw_clr(wr_acc ? wdata : '0), .q(act_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      grp_q <= '0;
      else if (wr_grp) grp_q <= wdata;
   end

   for (genvar c = 0; c < CFG_WORDS; c++) begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  cfg_q[c] <= '0;
         else if (wr_en && cfg_hit && cfg_idx == CIDX_W'(c)) cfg_q[c] <= wdata;
      end
   end

   pirq_prio_bank #(.NUM_INT(NUM_INT), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_prio (
      .clk(clk), .rst_n(rst_n), .wr(wr_en && prio_hit), .idx(prio_idx),
      .wdata(wdata), .rdata(prio_rdata));

   pirq_fwd #(.W(NUM_INT)) u_fwd (
      .clk(clk), .rst_n(rst_n), .pend(pend_q), .en(en_q), .act(act_q), .grp(grp_q),
      .g0_en(grp0_en), .g1_en(grp1_en), .irq(irq), .fiq(fiq));

   // ---------------- read mux ----------------
   always_comb begin
      rdata = '0;
      case (addr)
         A_GROUP:            rdata = grp_q;
         A_EN_SET, A_EN_CLR: rdata = en_q;
         A_PD_SET, A_PD_CLR: rdata = pend_q;
         A_AC_SET, A_AC_CLR: rdata = act_q;
         default: begin
            if (prio_hit)     rdata = prio_rdata;
            else if (cfg_hit) rdata = cfg_q[cfg_idx];
         end
      endcase
   end
endmodule

// File: rtl/pirq_state_chk.sv
module pirq_state_chk
   import pirq_pkg::*;
#(
   parameter int unsigned W       = 32,
   parameter int unsigned PPI_BIT = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [W-1:0]      wdata,
   input logic              sgi0,
   input logic              ppi0,
   input logic              g0_en,
   input logic              g1_en,
   input logic [W-1:0]      pend,
   input logic [W-1:0]      en,
   input logic [W-1:0]      act,
   input logic [W-1:0]      grp,
   input logic              irq,
   input logic              fiq
);
   p_irq_grp1_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq == $past((|(pend & en & ~act & grp)) && g1_en));

   p_fiq_grp0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fiq == $past((|(pend & en & ~act & ~grp)) && g0_en));

   p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(~|(pend & en & ~act)) |-> (!irq && !fiq));

   p_set_or_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_EN_SET) |=> ((en & $past(wdata)) == $past(wdata)));

   p_clr_andnot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_AC_CLR) |=> ((act & $past(wdata)) == '0));

   p_sgi_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sgi0) && !(wr_en && addr == A_PD_CLR && wdata[0])) |=> pend[0]);

   p_ppi_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ppi0) && !(wr_en && addr == A_PD_SET && wdata[PPI_BIT])) |=> !pend[PPI_BIT]);

   p_grp_replace_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_GROUP) |=> (grp == $past(wdata)));

   p_wr_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ppi0) && wr_en && addr == A_PD_CLR && wdata[PPI_BIT]) |=> !pend[PPI_BIT]);
endmodule

bind pirq_state pirq_state_chk #(.W(DATA_W), .PPI_BIT(NUM_SGI)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .sgi0(sgi_in[0]), .ppi0(ppi_in[0]), .g0_en(grp0_en), .g1_en(grp1_en),
   .pend(pend_q), .en(en_q), .act(act_q), .grp(grp_q), .irq(irq), .fiq(fiq));

// File: tb/sim_pirq_state.sv
`timescale 1ns/1ps
module sim_pirq_state;
   import pirq_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [15:0] sgi_in = '0;
   logic [15:0] ppi_in = '0;
   logic        grp0_en = 1'b0;
   logic        grp1_en = 1'b0;
   logic        irq, fiq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   pirq_state u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .sgi_in(sgi_in), .ppi_in(ppi_in),
      .grp0_en(grp0_en), .grp1_en(grp1_en), .irq(irq), .fiq(fiq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
      addr = a;
      #1;
      chk(req, rdata, exp);
   endtask

   task automatic t_reset;
      chk("R11 irq after reset", {31'b0, irq}, 32'h0);
      chk("R11 fiq after reset", {31'b0, fiq}, 32'h0);
      rd("R11 enable reset", A_EN_SET, 32'h0);
      rd("R11 pending reset", A_PD_SET, 32'h0);
      rd("R11 active reset", A_AC_SET, 32'h0);
      rd("R11 group reset", A_GROUP, 32'h0);
      rd("R11 prio reset", 5'd20, 32'h0);
      rd("R11 cfg reset", 5'd9, 32'h0);
   endtask

   task automatic t_aliases;
      wr(A_EN_SET, 32'hF0F0_0001);
      wr(A_EN_SET, 32'h0000_0100);
      rd("R5 enable set ORs", A_EN_SET, 32'hF0F0_0101);
      rd("R6 enable clear alias reads same", A_EN_CLR, 32'hF0F0_0101);
      wr(A_EN_CLR, 32'h0000_0F01);
      rd("R5 enable clear", A_EN_SET, 32'hF0F0_0000);
      wr(A_PD_SET, 32'h8000_0003);
      rd("R6 pending clear alias", A_PD_CLR, 32'h8000_0003);
      wr(A_PD_CLR, 32'h8000_0001);
      rd("R5 pending clear", A_PD_SET, 32'h0000_0002);
      wr(A_AC_SET, 32'h0001_0000);
      rd("R6 active clear alias", A_AC_CLR, 32'h0001_0000);
      wr(A_AC_CLR, 32'hFFFF_FFFF);
      rd("R5 active clear all", A_AC_SET, 32'h0);
      wr(A_EN_CLR, 32'hFFFF_FFFF);
      wr(A_PD_CLR, 32'hFFFF_FFFF);
   endtask

   task automatic t_group;
      wr(A_GROUP, 32'hFFFF_0000);
      wr(A_GROUP, 32'h0000_00FF);
      rd("R10 group replaced", A_GROUP, 32'h0000_00FF);
      wr(A_GROUP, 32'h0);
   endtask

   task automatic t_storage;
      wr(5'd19, 32'h4433_2211);
      wr(5'd16, 32'hA5A5_5A5A);
      rd("R7 prio word 3", 5'd19, 32'h4433_2211);
      rd("R7 prio word 0", 5'd16, 32'hA5A5_5A5A);
      rd("R7 prio word 2 untouched", 5'd18, 32'h0);
      rd("R7 prio word 7", 5'd23, 32'h0);
      wr(5'd8, 32'hDEAD_BEEF);
      wr(5'd9, 32'h1234_5678);
      rd("R8 cfg word 0", 5'd8, 32'hDEAD_BEEF);
      rd("R8 cfg word 1", 5'd9, 32'h1234_5678);
      wr(5'd12, 32'hFFFF_FFFF);
      rd("R8 unmapped reads zero", 5'd12, 32'h0);
   endtask

   task automatic t_lines;
      @(negedge clk); grp1_en = 1'b1; grp0_en = 1'b0;
      wr(A_GROUP, 32'h0000_0008);
      wr(A_EN_SET, 32'h0000_000C);
      wr(A_PD_SET, 32'h0000_0008);
      chk("R11 irq not yet moved", {31'b0, irq}, 32'h0);
      @(negedge clk);
      chk("R2 irq for group-1 source", {31'b0, irq}, 32'h1);
      chk("R3 fiq low with no group-0", {31'b0, fiq}, 32'h0);
      wr(A_PD_SET, 32'h0000_0004);
      @(negedge clk);
      chk("R3 fiq gated by grp0_en", {31'b0, fiq}, 32'h0);
      grp0_en = 1'b1;
      @(negedge clk);
      chk("R3 fiq for group-0 source", {31'b0, fiq}, 32'h1);
      grp1_en = 1'b0;
      @(negedge clk);
      chk("R2 irq gated by grp1_en", {31'b0, irq}, 32'h0);
      wr(A_AC_SET, 32'h0000_0004);
      @(negedge clk);
      chk("R1 active source not forwarded", {31'b0, fiq}, 32'h0);
      wr(A_AC_CLR, 32'h0000_0004);
      @(negedge clk);
      chk("R1 cleared active forwards again", {31'b0, fiq}, 32'h1);
      grp1_en = 1'b1;
      wr(A_PD_CLR, 32'h0000_000C);
      @(negedge clk);
      chk("R4 irq low when nothing forwardable", {31'b0, irq}, 32'h0);
      chk("R4 fiq low when nothing forwardable", {31'b0, fiq}, 32'h0);
      grp0_en = 1'b0; grp1_en = 1'b0;
      wr(A_EN_CLR, 32'hFFFF_FFFF);
      wr(A_GROUP, 32'h0);
   endtask

   task automatic t_hw;
      @(negedge clk); sgi_in[5] = 1'b1;
      @(negedge clk);
      rd("R9 sgi rise sets bit 5", A_PD_SET, 32'h0000_0020);
      sgi_in[5] = 1'b0;
      @(negedge clk);
      rd("R9 sgi fall clears bit 5", A_PD_SET, 32'h0);
      ppi_in[2] = 1'b1;
      @(negedge clk);
      rd("R9 ppi 2 maps to bit 18", A_PD_CLR, 32'h0004_0000);
      wr(A_PD_CLR, 32'h0004_0000);
      @(negedge clk);
      rd("R9 held level does not re-set", A_PD_SET, 32'h0);
      ppi_in[2] = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_collide;
      @(negedge clk);
      wr_en = 1'b1; addr = A_PD_CLR; wdata = 32'h0001_0000; ppi_in[0] = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      rd("R12 clear write beats rise", A_PD_SET, 32'h0);
      wr_en = 1'b1; addr = A_PD_SET; wdata = 32'h0001_0000; ppi_in[0] = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
      rd("R12 set write beats fall", A_PD_SET, 32'h0001_0000);
      wr(A_PD_CLR, 32'hFFFF_FFFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_aliases();
      t_group();
      t_storage();
      t_lines();
      t_hw();
      t_collide();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule